// File: doc/BRIEF.md
# AXI ID Filtered Transaction Counter Bank

This block is a small performance-monitor bank. It watches the read-address and write-address channels of an AXI memory port without driving them. It holds one free-running cycle counter and several event counters. Software gives each event counter an 8-bit event code. Code 0x41 counts read address handshakes and code 0x42 counts write address handshakes, but only those whose transaction ID passes one shared ID/compare-mask filter. Every other code leaves that counter idle.

A small control state machine drives the whole bank. It has three states:

- `CTL_IDLE`: counters hold their values.
- `CTL_COUNT`: counters advance.
- `CTL_CLEAR`: a one-cycle state that zeroes every counter and overflow flag.

It moves between states as follows:

- A control write with the clear bit set goes to `CTL_CLEAR` from any state.
- A control write without the clear bit goes to `CTL_COUNT` or `CTL_IDLE`, as the enable bit says.
- `CTL_CLEAR` leaves after one cycle, to `CTL_COUNT` if the stored enable bit is set and to `CTL_IDLE` if not.
- With no control write, `CTL_IDLE` and `CTL_COUNT` stay where they are.

Reads are combinational from a byte address. Writes take effect at the clock edge on which the write strobe is high.

Top module: `axid_perf_bank`

## Requirements
- R1: After reset, all counters, all overflow flags, the enable bit, every event code and the filter word read as zero.
- R2: While counting, counter 0 (read at address 0x00) increments by one on every clock edge, whatever its event code register holds. That register is fixed at 0x00.
- R3: A counter whose event code is 0x41 increments on each clock edge where ar_valid and ar_ready are both high and ((ar_id XOR fid) AND cmask) == 0. Here fid is filter bits [15:0] and cmask is filter bits [31:16]. The filter is at address 0x30.
- R4: A counter whose event code is 0x42 increments on each clock edge where aw_valid and aw_ready are both high and ((aw_id XOR fid) AND cmask) == 0.
- R5: A cmask bit of 1 compares that ID bit and a 0 ignores it. An all-ones cmask requires an exact match, and an all-zero cmask matches every ID.
- R6: The single filter word is used by every counter at once, so two counters holding the same filtered code always count identically.
- R7: A channel with only one of valid or ready high adds nothing to any event counter.
- R8: An event code other than 0x41 or 0x42 leaves that counter unchanged.
- R9: Control register 0x34 bit 0 is the enable. Writing it 0 moves the machine to `CTL_IDLE`, and from the next edge on all counters hold their values.
- R10: Writing control bit 1 as 1 enters `CTL_CLEAR`. On the next edge all counters and overflow flags become zero, and events on that edge are not counted. The machine then returns to `CTL_COUNT` or `CTL_IDLE` according to bit 0.
- R11: A counter changes by at most one per clock. When it steps from all ones it wraps to zero and sets its sticky overflow bit n in the status register at 0x38. That bit stays set until a clear.
- R12: Counter n reads at byte address 4*n, zero-extended to 32 bits. The event code of counter n reads at 0x20+4*n in bits [7:0], the filter word reads back unchanged, and control bit 0 reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 8 | Register write byte address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 8 | Register read byte address |
| reg_rdata | output | 32 | Register read data, combinational |
| ar_valid | input | 1 | Monitored read-address valid |
| ar_ready | input | 1 | Monitored read-address ready |
| ar_id | input | ID_W (16) | Monitored read transaction ID |
| aw_valid | input | 1 | Monitored write-address valid |
| aw_ready | input | 1 | Monitored write-address ready |
| aw_id | input | ID_W (16) | Monitored write transaction ID |

## Verification
The assertions assume that the event code of counter 1 is only meaningful for the edge at which it is sampled. They also assume that the monitored channels may toggle freely, because no protocol rule is checked. The stimulus changes the channels and the registers only at falling edges and holds each value for whole cycles. After every clear write it leaves one edge for `CTL_CLEAR` before any handshake it intends to count. The bench runs with an 8-bit counter width and a 4-bit ID so that it can sweep every ID against every filter ID and reach the wrap point.

// File: rtl/axid_perf_pkg.sv
package axid_perf_pkg;

    typedef enum logic [1:0] {
        CTL_IDLE  = 2'd0,
        CTL_COUNT = 2'd1,
        CTL_CLEAR = 2'd2
    } ctl_state_e;

    localparam logic [7:0] EVT_RD_ID   = 8'h41;
    localparam logic [7:0] EVT_WR_ID   = 8'h42;

    localparam logic [7:0] A_SEL_BASE  = 8'h20;
    localparam logic [7:0] A_FILT      = 8'h30;
    localparam logic [7:0] A_CTRL      = 8'h34;
    localparam logic [7:0] A_STAT      = 8'h38;

    localparam int unsigned FILT_MASK_LSB = 16;

endpackage

// File: rtl/axid_perf_ctrl.sv
module axid_perf_ctrl
    import axid_perf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_we,
    input  logic       cmd_en,
    input  logic       cmd_clr,
    output logic       count_en,
    output logic       clr_now,
    output logic       en_q,
    output ctl_state_e state_q
);

    ctl_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CTL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (cmd_we) begin
            en_q <= cmd_en;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (cmd_we) begin
            if (cmd_clr) begin
                state_d = CTL_CLEAR;
            end else if (cmd_en) begin
                state_d = CTL_COUNT;
            end else begin
                state_d = CTL_IDLE;
            end
        end else begin
            unique case (state_q)
                CTL_CLEAR: state_d = en_q ? CTL_COUNT : CTL_IDLE;
                CTL_IDLE:  state_d = CTL_IDLE;
                CTL_COUNT: state_d = CTL_COUNT;
                default:   state_d = CTL_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        count_en = 1'b0;
        clr_now  = 1'b0;
        unique case (state_q)
            CTL_COUNT: count_en = 1'b1;
            CTL_CLEAR: clr_now  = 1'b1;
            CTL_IDLE:  count_en = 1'b0;
            default:   count_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/axid_id_match.sv
module axid_id_match #(
    parameter int unsigned ID_W = 16
) (
    input  logic [ID_W-1:0] txn_id,
    input  logic [ID_W-1:0] filt_id,
    input  logic [ID_W-1:0] cmp_mask,
    output logic            hit
);

    logic [ID_W-1:0] diff;

    always_comb begin
        diff = (txn_id ^ filt_id) & cmp_mask;
        hit  = (diff == '0);
    end

endmodule

// File: rtl/axid_evt_gate.sv
module axid_evt_gate
    import axid_perf_pkg::*;
(
    input  logic [7:0] code,
    input  logic       rd_hit,
    input  logic       wr_hit,
    output logic       step
);

    always_comb begin
        case (code)
            EVT_RD_ID: step = rd_hit;
            EVT_WR_ID: step = wr_hit;
            default:   step = 1'b0;
        endcase
    end

endmodule

// File: rtl/axid_perf_counter.sv
module axid_perf_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] value,
    output logic             wrapped
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value   <= '0;
            wrapped <= 1'b0;
        end else if (clr) begin
            value   <= '0;
            wrapped <= 1'b0;
        end else if (inc) begin
            value <= value + 1'b1;
            if (&value) begin
                wrapped <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/axid_perf_bank.sv
module axid_perf_bank
    import axid_perf_pkg::*;
#(
    parameter int unsigned N_CNT = 4,
    parameter int unsigned CNT_W = 32,
    parameter int unsigned ID_W  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [7:0]      reg_waddr,
    input  logic [31:0]     reg_wdata,
    input  logic [7:0]      reg_raddr,
    output logic [31:0]     reg_rdata,
    input  logic            ar_valid,
    input  logic            ar_ready,
    input  logic [ID_W-1:0] ar_id,
    input  logic            aw_valid,
    input  logic            aw_ready,
    input  logic [ID_W-1:0] aw_id
);

    localparam int unsigned FLAT_W = N_CNT * CNT_W;

    logic [31:0]               filt_q;
    logic [N_CNT-1:0][7:0]     sel_q;
    logic [FLAT_W-1:0]         cnt_flat;
    logic [N_CNT-1:0]          ovf_q;
    logic                      count_en;
    logic                      clr_pulse;
    logic                      en_q;
    ctl_state_e                ctl_state;
    logic                      ctrl_we;
    logic                      ar_fire;
    logic                      aw_fire;
    logic                      rd_match;
    logic                      wr_match;
    logic [ID_W-1:0]           fid;
    logic [ID_W-1:0]           cmask;

    assign ctrl_we = reg_we && (reg_waddr == A_CTRL);
    assign ar_fire = ar_valid && ar_ready;
    assign aw_fire = aw_valid && aw_ready;
    assign fid     = filt_q[ID_W-1:0];
    assign cmask   = filt_q[FILT_MASK_LSB +: ID_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q <= '0;
        end else if (reg_we && (reg_waddr == A_FILT)) begin
            filt_q <= reg_wdata;
        end
    end

    // event codes; counter 0 is fixed to the cycle count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            for (int i = 1; i < N_CNT; i++) begin
                if (reg_we && (reg_waddr == A_SEL_BASE + 8'(4 * i))) begin
                    sel_q[i] <= reg_wdata[7:0];
                end
            end
        end
    end

    axid_perf_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_we   (ctrl_we),
        .cmd_en   (reg_wdata[0]),
        .cmd_clr  (reg_wdata[1]),
        .count_en (count_en),
        .clr_now  (clr_pulse),
        .en_q     (en_q),
        .state_q  (ctl_state)
    );

    axid_id_match #(.ID_W(ID_W)) u_rd_match (
        .txn_id   (ar_id),
        .filt_id  (fid),
        .cmp_mask (cmask),
        .hit      (rd_match)
    );

    axid_id_match #(.ID_W(ID_W)) u_wr_match (
        .txn_id   (aw_id),
        .filt_id  (fid),
        .cmp_mask (cmask),
        .hit      (wr_match)
    );

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        logic inc;
        if (g == 0) begin : g_cycle
            assign inc = count_en;
        end else begin : g_event
            logic step;
            axid_evt_gate u_gate (
                .code   (sel_q[g]),
                .rd_hit (ar_fire && rd_match),
                .wr_hit (aw_fire && wr_match),
                .step   (step)
            );
            assign inc = count_en && step;
        end
        axid_perf_counter #(.CNT_W(CNT_W)) u_counter (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr_pulse),
            .inc     (inc),
            .value   (cnt_flat[g*CNT_W +: CNT_W]),
            .wrapped (ovf_q[g])
        );
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < N_CNT; i++) begin
            if (reg_raddr == 8'(4 * i)) begin
                reg_rdata[CNT_W-1:0] = cnt_flat[i*CNT_W +: CNT_W];
            end
            if (reg_raddr == A_SEL_BASE + 8'(4 * i)) begin
                reg_rdata[7:0] = sel_q[i];
            end
        end
        if (reg_raddr == A_FILT) begin
            reg_rdata = filt_q;
        end
        if (reg_raddr == A_CTRL) begin
            reg_rdata[0] = en_q;
        end
        if (reg_raddr == A_STAT) begin
            reg_rdata[N_CNT-1:0] = ovf_q;
        end
    end

endmodule

// File: rtl/axid_perf_bank_chk.sv
module axid_perf_bank_chk #(
    parameter int unsigned N_CNT = 4,
    parameter int unsigned CNT_W = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   count_en,
    input logic                   clr,
    input logic [N_CNT*CNT_W-1:0] cnt_flat,
    input logic [N_CNT-1:0]       ovf,
    input logic [7:0]             sel1,
    input logic                   ar_fire,
    input logic                   aw_fire
);

    logic [CNT_W-1:0] cnt0;
    logic [CNT_W-1:0] cnt1;
    assign cnt0 = cnt_flat[CNT_W-1:0];
    assign cnt1 = cnt_flat[2*CNT_W-1:CNT_W];

    AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        count_en |=> cnt0 == CNT_W'($past(cnt0) + 1'b1)); // R2

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_flat == '0) && (ovf == '0)); // R10

    AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(count_en && clr)); // R10

    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !clr) |=> $stable(cnt_flat)); // R9

    AST_NO_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ar_fire && !aw_fire && !clr) |=> $stable(cnt1)); // R7

    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel1 != 8'h41 && sel1 != 8'h42 && !clr) |=> $stable(cnt1)); // R8

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt1 == $past(cnt1)) || (cnt1 == CNT_W'($past(cnt1) + 1'b1))); // R11

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (ovf & $past(ovf)) == $past(ovf)); // R11

endmodule

bind axid_perf_bank axid_perf_bank_chk #(.N_CNT(N_CNT), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (count_en),
    .clr      (clr_pulse),
    .cnt_flat (cnt_flat),
    .ovf      (ovf_q),
    .sel1     (sel_q[1]),
    .ar_fire  (ar_fire),
    .aw_fire  (aw_fire)
);

// File: tb/axid_perf_bank_bench.sv
`timescale 1ns/1ps
module axid_perf_bank_bench;

    localparam int unsigned N_CNT = 4;
    localparam int unsigned CNT_W = 8;
    localparam int unsigned ID_W  = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_we = 1'b0;
    logic [7:0]      reg_waddr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [7:0]      reg_raddr = '0;
    logic [31:0]     reg_rdata;
    logic            ar_valid = 1'b0;
    logic            ar_ready = 1'b0;
    logic [ID_W-1:0] ar_id = '0;
    logic            aw_valid = 1'b0;
    logic            aw_ready = 1'b0;
    logic [ID_W-1:0] aw_id = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    axid_perf_bank #(.N_CNT(N_CNT), .CNT_W(CNT_W), .ID_W(ID_W)) u_axid_perf_bank (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle_chan();
        ar_valid = 1'b0; ar_ready = 1'b0; aw_valid = 1'b0; aw_ready = 1'b0;
    endtask

    // set the filter and clear/enable; the clear edge elapses before the next task drives
    task automatic arm(input logic [3:0] mask, input logic [3:0] fid);
        wr(8'h30, {12'h0, mask, 12'h0, fid});
        wr(8'h34, 32'h3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, a0, b0;
        logic [3:0]  masks [5];
        masks[0] = 4'hF; masks[1] = 4'hC; masks[2] = 4'h0; masks[3] = 4'hA; masks[4] = 4'h5;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < N_CNT; i++) begin
            rd(8'(4 * i), v);          check("R1 counter", v, 0);
            rd(8'(8'h20 + 4 * i), v);  check("R1 code", v, 0);
        end
        rd(8'h30, v); check("R1 filter", v, 0);
        rd(8'h34, v); check("R1 enable", v, 0);
        rd(8'h38, v); check("R1 status", v, 0);

        // R12 register readback
        wr(8'h24, 32'h41); wr(8'h28, 32'h42); wr(8'h2C, 32'h41); wr(8'h20, 32'hAB);
        rd(8'h24, v); check("R12 code1", v, 32'h41);
        rd(8'h28, v); check("R12 code2", v, 32'h42);
        rd(8'h2C, v); check("R12 code3", v, 32'h41);
        rd(8'h20, v); check("R12 code0 fixed", v, 0);
        wr(8'h30, 32'h000C0005);
        rd(8'h30, v); check("R12 filter", v, 32'h000C0005);

        // R2 cycle counter
        wr(8'h34, 32'h1);
        rd(8'h34, v); check("R12 enable readback", v, 1);
        rd(8'h00, a0);
        repeat (37) @(negedge clk);
        rd(8'h00, b0);
        check("R2 cycle delta", (b0 - a0) & 32'hFF, 37);

        // R3 R4 R5 R6 sweep of every filter id, five masks, every transaction id
        for (int m = 0; m < 5; m++) begin
            for (int f = 0; f < 16; f++) begin
                int exp_n;
                arm(masks[m], 4'(f));
                exp_n = 0;
                for (int id = 0; id < 16; id++) begin
                    if (((4'(id) ^ 4'(f)) & masks[m]) == 4'h0) exp_n++;
                end
                for (int id = 0; id < 16; id++) begin
                    @(negedge clk);
                    ar_valid = 1'b1; ar_ready = 1'b1; ar_id = 4'(id);
                    aw_valid = 1'b1; aw_ready = 1'b1; aw_id = 4'(15 - id);
                end
                @(negedge clk);
                idle_chan();
                rd(8'h04, v); check("R3/R5 read filtered", v, 32'(exp_n));
                rd(8'h08, v); check("R4/R5 write filtered", v, 32'(exp_n));
                rd(8'h0C, v); check("R6 shared filter", v, 32'(exp_n));
            end
        end

        // R7 half handshakes
        arm(4'h0, 4'h0);
        @(negedge clk); ar_valid = 1'b1; aw_valid = 1'b1;
        repeat (4) @(negedge clk);
        ar_valid = 1'b0; aw_valid = 1'b0; ar_ready = 1'b1; aw_ready = 1'b1;
        repeat (4) @(negedge clk);
        idle_chan();
        rd(8'h04, v); check("R7 read half", v, 0);
        rd(8'h08, v); check("R7 write half", v, 0);
        ar_valid = 1'b1; ar_ready = 1'b1;
        @(negedge clk);
        idle_chan();
        rd(8'h04, v); check("R3 single beat", v, 1);

        // R8 unrecognised codes
        wr(8'h24, 32'h43); wr(8'h28, 32'h00); wr(8'h2C, 32'hFF);
        wr(8'h34, 32'h3);
        @(negedge clk);
        ar_valid = 1'b1; ar_ready = 1'b1; aw_valid = 1'b1; aw_ready = 1'b1;
        repeat (10) @(negedge clk);
        idle_chan();
        rd(8'h04, v); check("R8 code 43", v, 0);
        rd(8'h08, v); check("R8 code 00", v, 0);
        rd(8'h0C, v); check("R8 code FF", v, 0);

        // R9 disable freezes
        wr(8'h24, 32'h41);
        wr(8'h34, 32'h3);
        @(negedge clk); ar_valid = 1'b1; ar_ready = 1'b1;
        repeat (4) @(negedge clk);
        idle_chan();
        rd(8'h04, v); check("R9 before disable", v, 4);
        wr(8'h34, 32'h0);
        rd(8'h00, a0);
        ar_valid = 1'b1; ar_ready = 1'b1;
        repeat (6) @(negedge clk);
        idle_chan();
        rd(8'h04, v); check("R9 event frozen", v, 4);
        rd(8'h00, b0); check("R9 cycle frozen", b0, a0);

        // R11 wrap and sticky overflow
        wr(8'h2C, 32'h00);
        wr(8'h34, 32'h3);
        @(negedge clk); ar_valid = 1'b1; ar_ready = 1'b1;
        repeat (255) @(negedge clk);
        rd(8'h04, v); check("R11 at max", v, 255);
        rd(8'h38, v); check("R11 no overflow yet", v & 32'h2, 0);
        @(negedge clk);
        rd(8'h04, v); check("R11 wrapped", v, 0);
        rd(8'h38, v); check("R11 overflow set", v, 32'h3);
        repeat (3) @(negedge clk);
        idle_chan();
        rd(8'h04, v); check("R11 after wrap", v, 3);
        rd(8'h38, v); check("R11 sticky", v, 32'h3);

        // R10 clear with enable low
        wr(8'h34, 32'h2);
        @(negedge clk);
        for (int i = 0; i < N_CNT; i++) begin
            rd(8'(4 * i), v); check("R10 counter zero", v, 0);
        end
        rd(8'h38, v); check("R10 status zero", v, 0);
        rd(8'h34, v); check("R10 enable low", v, 0);
        ar_valid = 1'b1; ar_ready = 1'b1;
        repeat (5) @(negedge clk);
        idle_chan();
        rd(8'h04, v); check("R10 stays idle", v, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule